// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a register bus and a one-time-programmable fuse store of 8 banks, each holding 256 eight-bit words. Software uses a small set of byte registers to aim at a single fuse bit and to launch one of two timed operations. A program operation permanently sets the addressed bit. An explicit sense operation copies the raw fused byte of the addressed word into a result register. While an operation runs, a busy flag is raised. When it finishes, a per-operation done flag is set. Rejected requests raise error flags, and a level interrupt reports any done or error flag that software has enabled.

Every fuse word can also be reached through a direct window, which returns a shadow copy of the word. Software can load an override value into this shadow without touching the fuses. Each bank has its own protection for reading, for overriding and for programming. These protections come from a vector that the controller captures while reset is held. A program request also needs a key byte to be present in a dedicated register at the moment it is issued.

Top module: `efuse_ctrl`

## Requirements
- R1: Register offsets use busAddr[11]=0 and busAddr[3:0]. The map is: 0 status, 1 status mask, 2 error, 3 error mask, 4 function control, 5 upper address, 6 lower address, 7 sense data, 8 key. Reading an unused offset returns 0. After reset all registers read 0, irq is low, and every window word reads 0.
- R2: The fuse address is made of three fields. Bank is upper[5:3]. Word is {upper[2:0], lower[7:3]}. Bit is lower[2:0]. The window is at busAddr = {1'b1, bank[2:0], word[7:0]}. A completed program sets only the addressed bit. It also reloads that word's shadow from the fuses, so any override on that word is dropped.
- R3: Writing function control with bit 0 set starts a program only if the key register holds 0xAA at that write. Otherwise, error bit 6 is set, busy stays low and no fuse changes.
- R4: Status bit 7 shows busy. A program keeps it high for PROG_CYCLES*(L+1) cycles, where L is function control bits 6:4. A sense keeps it high for SENSE_CYCLES cycles. The defaults are 16 and 4.
- R5: When an operation finishes, busy falls. In the same cycle, status bit 1 (program) or status bit 0 (sense) is set, and function control bits 0 and 3 read back 0.
- R6: Writing function control with bit 3 set (and bit 0 clear) starts a sense. The sense loads the sense-data register with the raw fused byte, not with the shadow.
- R7: A window write loads the word's shadow, and later window reads return it. If the bank is override-protected, error bit 5 is set and the shadow is left unchanged.
- R8: A window read (busRd) of a read-protected bank returns 0 and sets error bit 4. A sense request on a read-protected bank sets error bit 2 at once and does not start.
- R9: A keyed program request on a write-protected bank sets error bit 3 and changes no fuse.
- R10: A keyed program request with function control bit 7 set sets error bit 7, does not raise busy, and changes no fuse.
- R11: Writing 1 to status bits 1:0 or error bits 7:2 clears those bits. The status mask holds bits 1:0 and the error mask holds bits 7:1.
- R12: irq is high exactly when some status or error bit is set whose mask bit is also set.
- R13: While busy, writes to function control, upper address and lower address are ignored. This means a second start request has no effect.
- R14: protIn is captured while rstN is low. For bank b, bit 3b is read protect, bit 3b+1 is override protect, and bit 3b+2 is write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; protIn is sampled while it is low |
| protIn | input | 24 | Per-bank protect bits {write, override, read} |
| busAddr | input | 12 | Register offset or window address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (gives window reads their side effect) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
Programs are run at two different bit positions of one word, and with two program lengths. This separates a correct bit decode and a correct duration scaling from merely shifted or fixed behaviour. A neighbouring word is read after each program, which exposes a wrong word field. An override placed before a sense shows whether the sense returns raw fuse data or shadow data. Each rejection path (bad key, write lock, disabled program cycle, override lock, read lock) is triggered on its own and checked both for its error bit and for the absence of any fuse or shadow change. Start and address writes issued mid-operation confirm that the running operation is left undisturbed.

// File: rtl/efuse_ctrl_pkg.sv
package efuse_ctrl_pkg;
  localparam int BANK_W    = 3;
  localparam int WORD_W    = 8;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int IDX_W     = BANK_W + WORD_W;
  localparam int NUM_WORDS = 1 << IDX_W;
  localparam int ADDR_W    = IDX_W + 1;
  localparam int PROT_W    = 3 * NUM_BANKS;
  localparam logic [7:0] KEY_VALUE = 8'hAA;

  localparam logic [3:0] REG_STAT  = 4'd0;
  localparam logic [3:0] REG_STATM = 4'd1;
  localparam logic [3:0] REG_ERR   = 4'd2;
  localparam logic [3:0] REG_EMASK = 4'd3;
  localparam logic [3:0] REG_FCTL  = 4'd4;
  localparam logic [3:0] REG_UPPER = 4'd5;
  localparam logic [3:0] REG_LOWER = 4'd6;
  localparam logic [3:0] REG_SDAT  = 4'd7;
  localparam logic [3:0] REG_KEY   = 4'd8;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic busy;
    logic launchProg;
    logic launchSense;
    logic doneProg;
    logic doneSense;
    logic errKey;
    logic errLock;
    logic errPrgOff;
    logic errSense;
  } seqStrobe_t;
endpackage

// File: rtl/efuse_ctrl_seq.sv
module efuse_ctrl_seq
  import efuse_ctrl_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int SENSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fctlWr,
  input  logic       reqProg,
  input  logic       reqSense,
  input  logic       progOff,
  input  logic [2:0] progLen,
  input  logic       keyOk,
  input  logic       wrLocked,
  input  logic       rdLocked,
  output seqStrobe_t ctl
);
  localparam int CNT_W = $clog2(PROG_CYCLES * 8 + 1);

  logic             busyQ;
  logic             opProg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] progLoad;

  assign progLoad = CNT_W'(PROG_CYCLES) * (CNT_W'(progLen) + CNT_W'(1)) - CNT_W'(1);

  always_comb begin
    ctl = '0;
    ctl.busy = busyQ;
    if (!busyQ && fctlWr) begin
      if (reqProg) begin
        if (!keyOk)        ctl.errKey     = 1'b1;
        else if (wrLocked) ctl.errLock    = 1'b1;
        else if (progOff)  ctl.errPrgOff  = 1'b1;
        else               ctl.launchProg = 1'b1;
      end else if (reqSense) begin
        if (rdLocked) ctl.errSense    = 1'b1;
        else          ctl.launchSense = 1'b1;
      end
    end
    ctl.doneProg  = busyQ && (cnt == '0) && opProg;
    ctl.doneSense = busyQ && (cnt == '0) && !opProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      opProg <= 1'b0;
      cnt    <= '0;
    end else if (ctl.launchProg) begin
      busyQ  <= 1'b1;
      opProg <= 1'b1;
      cnt    <= progLoad;
    end else if (ctl.launchSense) begin
      busyQ  <= 1'b1;
      opProg <= 1'b0;
      cnt    <= CNT_W'(SENSE_CYCLES - 1);
    end else if (busyQ) begin
      if (cnt == '0) busyQ <= 1'b0;
      else           cnt   <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/efuse_ctrl_dp.sv
module efuse_ctrl_dp
  import efuse_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PROT_W-1:0] protIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irq,
  input  seqStrobe_t        ctl,
  output logic              fctlWr,
  output logic              keyOk,
  output logic              wrLocked,
  output logic              rdLocked
);
  logic [1:0] statDone, statMask;
  logic [7:2] errQ;
  logic [7:1] errMask;
  logic [7:0] fctlQ, lowerQ, sdatQ, keyQ;
  logic [5:0] upperQ;
  logic [NUM_BANKS-1:0] protRdQ, protOvrQ, protWrQ;
  logic [7:0] fuseMem   [NUM_WORDS];
  logic [7:0] shadowMem [NUM_WORDS];

  logic              isWin;
  logic [3:0]        regIdx;
  logic [BANK_W-1:0] winBank, opBank;
  logic [IDX_W-1:0]  winIdx, opIdx;
  logic [2:0]        opBit;
  logic              winWr, winRd, ovrBlocked, rdBlocked;

  assign isWin    = busAddr[ADDR_W-1];
  assign regIdx   = busAddr[3:0];
  assign winIdx   = busAddr[IDX_W-1:0];
  assign winBank  = busAddr[IDX_W-1 -: BANK_W];
  assign opBank   = upperQ[5:3];
  assign opIdx    = {upperQ, lowerQ[7:3]};
  assign opBit    = lowerQ[2:0];
  assign winWr    = busWr && isWin;
  assign winRd    = busRd && isWin;
  assign ovrBlocked = winWr && protOvrQ[winBank];
  assign rdBlocked  = winRd && protRdQ[winBank];

  assign fctlWr   = busWr && !isWin && regIdx == REG_FCTL;
  assign keyOk    = keyQ == KEY_VALUE;
  assign wrLocked = protWrQ[opBank];
  assign rdLocked = protRdQ[opBank];

  function automatic logic regHit(input logic [3:0] idx);
    return busWr && !isWin && regIdx == idx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statDone <= '0; statMask <= '0; errQ <= '0; errMask <= '0;
      fctlQ <= '0; upperQ <= '0; lowerQ <= '0; sdatQ <= '0; keyQ <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        protRdQ[b]  <= protIn[3*b];
        protOvrQ[b] <= protIn[3*b+1];
        protWrQ[b]  <= protIn[3*b+2];
      end
    end else begin
      statDone <= (statDone & ~(regHit(REG_STAT) ? busWdata[1:0] : 2'b00))
                | {ctl.doneProg, ctl.doneSense};
      errQ <= (errQ & ~(regHit(REG_ERR) ? busWdata[7:2] : 6'b0))
            | {ctl.errPrgOff, ctl.errKey, ovrBlocked, rdBlocked, ctl.errLock, ctl.errSense};
      if (regHit(REG_STATM)) statMask <= busWdata[1:0];
      if (regHit(REG_EMASK)) errMask  <= busWdata[7:1];
      if (regHit(REG_KEY))   keyQ     <= busWdata;
      if (!ctl.busy) begin
        if (regHit(REG_UPPER)) upperQ <= busWdata[5:0];
        if (regHit(REG_LOWER)) lowerQ <= busWdata;
        if (fctlWr)
          fctlQ <= (busWdata & 8'hF6) | {4'b0, ctl.launchSense, 2'b0, ctl.launchProg};
      end
      if (ctl.doneProg || ctl.doneSense) begin
        fctlQ[0] <= 1'b0;
        fctlQ[3] <= 1'b0;
      end
      if (ctl.doneSense) sdatQ <= fuseMem[opIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        fuseMem[i]   <= '0;
        shadowMem[i] <= '0;
      end
    end else begin
      if (winWr && !protOvrQ[winBank]) shadowMem[winIdx] <= busWdata;
      if (ctl.doneProg) begin
        fuseMem[opIdx][opBit] <= 1'b1;
        shadowMem[opIdx]      <= fuseMem[opIdx] | (8'b1 << opBit);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (isWin) begin
      if (!protRdQ[winBank]) busRdata = shadowMem[winIdx];
    end else begin
      case (regIdx)
        REG_STAT:  busRdata = {ctl.busy, 5'b0, statDone};
        REG_STATM: busRdata = {6'b0, statMask};
        REG_ERR:   busRdata = {errQ, 2'b0};
        REG_EMASK: busRdata = {errMask, 1'b0};
        REG_FCTL:  busRdata = fctlQ;
        REG_UPPER: busRdata = {2'b0, upperQ};
        REG_LOWER: busRdata = lowerQ;
        REG_SDAT:  busRdata = sdatQ;
        REG_KEY:   busRdata = keyQ;
        default:   busRdata = '0;
      endcase
    end
  end

  assign irq = |(statDone & statMask) || |(errQ & errMask[7:2]);

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && regHit(REG_UPPER)) |=> $stable(upperQ)) else $error("upper address changed while busy"); // R13
  AST_BIT_BLOWN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doneProg |=> fuseMem[opIdx][opBit]) else $error("programmed bit not set"); // R2
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.busy) |-> (statDone != 2'b00)) else $error("busy fell without done"); // R5
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (fctlWr && busWdata[0] && !ctl.busy && keyQ != KEY_VALUE) |=> (errQ[6] && !ctl.busy)) else $error("bad key accepted"); // R3
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
  import efuse_ctrl_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int SENSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PROT_W-1:0] protIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irq
);
  seqStrobe_t ctl;
  logic fctlWr, keyOk, wrLocked, rdLocked;

  efuse_ctrl_seq #(
    .PROG_CYCLES (PROG_CYCLES),
    .SENSE_CYCLES(SENSE_CYCLES)
  ) seq_i (
    .clk     (clk),
    .rstN    (rstN),
    .fctlWr  (fctlWr),
    .reqProg (busWdata[0]),
    .reqSense(busWdata[3]),
    .progOff (busWdata[7]),
    .progLen (busWdata[6:4]),
    .keyOk   (keyOk),
    .wrLocked(wrLocked),
    .rdLocked(rdLocked),
    .ctl     (ctl)
  );

  efuse_ctrl_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .protIn  (protIn),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq),
    .ctl     (ctl),
    .fctlWr  (fctlWr),
    .keyOk   (keyOk),
    .wrLocked(wrLocked),
    .rdLocked(rdLocked)
  );
endmodule

// File: tb/efuse_ctrl_tb_top.sv
module efuse_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] protIn = 24'h888000; // bank5 read, bank6 override, bank7 write protected
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  efuse_ctrl dut_i (
    .clk(clk), .rstN(rstN), .protIn(protIn), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; #1;
    d = busRdata;
  endtask

  function automatic logic [11:0] win(input int bank, input int word);
    return {1'b1, 3'(bank), 8'(word)};
  endfunction

  task automatic aim(input int bank, input int word, input int bitIdx);
    wr(12'h005, 8'((bank << 3) | (word >> 5)));
    wr(12'h006, 8'(((word << 3) | bitIdx) & 8'hFF));
  endtask

  task automatic busyCount(output int n);
    logic [7:0] s;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(12'h000, s);
      if (!s[7]) break;
      n++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int r = 0; r < 9; r++) begin
      rd(12'(r), v); chk("R1 reg reset", v, 0);
    end
    rd(win(3, 200), v); chk("R1 window reset", v, 0);
    chk("R1 irq reset", irq, 0);
  endtask

  task automatic t_program;
    logic [7:0] v; int n;
    wr(12'h008, 8'hAA);
    aim(2, 8'h47, 5);
    wr(12'h004, 8'h01);
    busyCount(n); chk("R4 program busy cycles len0", n, 16);
    rd(12'h000, v); chk("R5 program done status", v, 8'h02);
    rd(12'h004, v); chk("R5 start bit self-clear", v, 8'h00);
    rd(win(2, 8'h47), v); chk("R2 addressed bit blown", v, 8'h20);
    rd(win(2, 8'h46), v); chk("R2 neighbour word untouched", v, 8'h00);
    wr(win(2, 8'h47), 8'hC3);
    aim(2, 8'h47, 0);
    wr(12'h004, 8'h21);
    busyCount(n); chk("R4 program busy cycles len2", n, 48);
    rd(win(2, 8'h47), v); chk("R2 second bit, override dropped", v, 8'h21);
    wr(12'h000, 8'h02);
    rd(12'h000, v); chk("R11 status w1c", v, 8'h00);
  endtask

  task automatic t_bad_key;
    logic [7:0] v;
    wr(12'h008, 8'h55);
    aim(3, 1, 7);
    wr(12'h004, 8'h01);
    rd(12'h000, v); chk("R3 no busy on bad key", v, 8'h00);
    rd(12'h002, v); chk("R3 key error bit6", v, 8'h40);
    rd(win(3, 1), v); chk("R3 no fuse change", v, 8'h00);
    wr(12'h002, 8'h40);
    rd(12'h002, v); chk("R11 error w1c", v, 8'h00);
  endtask

  task automatic t_sense;
    logic [7:0] v; int n;
    wr(win(2, 8'h47), 8'h5A);
    rd(win(2, 8'h47), v); chk("R7 override readback", v, 8'h5A);
    aim(2, 8'h47, 0);
    wr(12'h004, 8'h08);
    busyCount(n); chk("R4 sense busy cycles", n, 4);
    rd(12'h000, v); chk("R5 sense done status", v, 8'h01);
    rd(12'h007, v); chk("R6 sense returns raw fuse", v, 8'h21);
    wr(12'h000, 8'h01);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wr(win(6, 3), 8'hFF);
    rd(12'h002, v); chk("R7 override protect error", v, 8'h20);
    rd(win(6, 3), v); chk("R7 shadow unchanged", v, 8'h00);
    wr(12'h002, 8'hFC);
    @(negedge clk); busAddr = win(5, 9); busRd = 1'b1; #1;
    v = busRdata; chk("R8 read-protected window returns 0", v, 8'h00);
    @(posedge clk); #1; busRd = 1'b0;
    rd(12'h002, v); chk("R8 read protect error", v, 8'h10);
    wr(12'h002, 8'hFC);
    aim(5, 9, 0);
    wr(12'h004, 8'h08);
    rd(12'h000, v); chk("R8 sense not started", v, 8'h00);
    rd(12'h002, v); chk("R8 sense error", v, 8'h04);
    wr(12'h002, 8'hFC);
    wr(12'h008, 8'hAA);
    aim(7, 0, 0);
    wr(12'h004, 8'h01);
    rd(12'h002, v); chk("R9 write lock error", v, 8'h08);
    rd(win(7, 0), v); chk("R9 no fuse change", v, 8'h00);
    wr(12'h002, 8'hFC);
    aim(1, 0, 0);
    wr(12'h004, 8'h81);
    rd(12'h000, v); chk("R10 no busy", v, 8'h00);
    rd(12'h002, v); chk("R10 program error", v, 8'h80);
    rd(win(1, 0), v); chk("R10 no fuse change", v, 8'h00);
    wr(12'h002, 8'hFC);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v; int n;
    aim(0, 0, 1);
    wr(12'h004, 8'h01);
    wr(12'h005, 8'h3F);
    wr(12'h006, 8'hFF);
    wr(12'h004, 8'h08);
    rd(12'h005, v); chk("R13 upper frozen", v, 8'h00);
    rd(12'h006, v); chk("R13 lower frozen", v, 8'h01);
    rd(12'h004, v); chk("R13 control frozen", v, 8'h01);
    busyCount(n);
    rd(12'h000, v); chk("R13 only program completes", v, 8'h02);
    rd(win(0, 0), v); chk("R13 original target blown", v, 8'h02);
    rd(12'h007, v); chk("R13 sense data untouched", v, 8'h21);
  endtask

  task automatic t_irq;
    wr(12'h001, 8'h00); @(negedge clk); chk("R12 masked done no irq", irq, 0);
    wr(12'h001, 8'h02); @(negedge clk); chk("R12 enabled done irq", irq, 1);
    wr(12'h000, 8'h02); @(negedge clk); chk("R12 cleared done no irq", irq, 0);
    wr(12'h008, 8'h00);
    wr(12'h004, 8'h01); @(negedge clk); chk("R12 unmasked error no irq", irq, 0);
    wr(12'h003, 8'h40); @(negedge clk); chk("R12 enabled error irq", irq, 1);
    wr(12'h003, 8'h20); @(negedge clk); chk("R12 other mask no irq", irq, 0);
  endtask

  task automatic t_prot_capture;
    logic [7:0] v;
    // R14: bank5 read protected comes from protIn bit 15; bank 4 (bit 12 clear) is readable
    rd(win(4, 0), v); chk("R14 unprotected bank readable", v, 8'h00);
    @(negedge clk); busAddr = win(4, 0); busRd = 1'b1;
    @(posedge clk); #1; busRd = 1'b0;
    rd(12'h002, v); chk("R14 no error on unprotected bank", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    protIn = 24'h0;
    t_reset();
    t_program();
    t_bad_key();
    t_sense();
    t_protect();
    t_busy_ignore();
    t_prot_capture();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule